// File: doc/BRIEF.md
# Programmable Link LED Mapper

This block turns Ethernet PHY status into the drive for three multi-function pins that can show link state on LEDs, plus a fourth pin that carries only a general purpose value. The PHY status it consumes is link up, the negotiated speed (10, 100 or 1000 Mb/s), full duplex, and a single-cycle strobe for each transmitted or received frame. A 16-bit mode word assigns each LED a 5-bit selection field. A master bit in that word chooses between the programmed fields and a fixed set of defaults.

Each selection field holds four options that can be combined. Any subset of the three speeds can be chosen, and the LED lights while the link is up at one of the chosen speeds. A duplex qualifier requires full duplex. An activity option stretches short activity strobes into a visible pulse. When activity is combined with a link condition, the LED stays lit while the link holds and blinks off while traffic is seen.

A per-pin enable selects either the LED function or a host-written value for each of pins 0 to 2. When the host value is selected, the host-written output enable drives the pin's enable. Pin 3 always takes its host value and host enable. All pin values and output enables come from registers.

Top module: `led_pin_mapper`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pin_out` and `pin_oe` are cleared to all zeros at that edge.
- R2: When `mode_word[15]` is 1, LED0 uses `mode_word[4:0]`, LED1 uses `mode_word[9:5]` and LED2 uses `mode_word[14:10]`. Within a field, bit 0 selects activity, bit 1 selects link at 10, bit 2 selects link at 100, bit 3 selects link at 1000, and bit 4 selects full duplex.
- R3: When `mode_word[15]` is 0, the fields are ignored. LED0 behaves as field 5'b00001 (activity only), LED1 as 5'b01110 (link at any speed), and LED2 as 5'b01111 (link at any speed plus activity).
- R4: Speed is encoded on `speed` as 2'b00 = 10, 2'b01 = 100, 2'b10 = 1000, and 2'b11 = no valid speed. An LED with speed bits set is lit only while `link_up` is 1 and `speed` equals one of the selected speeds. Code 2'b11 matches no speed bit.
- R5: When the duplex bit of a field is set, the LED is lit only while `link_up` and `full_duplex` are both 1. The duplex condition is ANDed with any speed condition in the same field.
- R6: An activity-only field (5'b00001) lights the LED from the first cycle after a cycle with `activity` high. The LED stays lit for STRETCH_CYCLES cycles after the last such cycle and then turns off.
- R7: For a field with activity and at least one link condition, the LED is steadily lit while the link condition holds and no activity stretch is running. While a stretch is running, the LED alternates off and on every BLINK_HALF cycles.
- R8: A field of all zeros keeps the LED off (`pin_out` bit 0) in LED function.
- R9: For pin i in 0 to 2, `pin_led_en[i]` = 1 gives the LED value with `pin_oe[i]` = 1. When it is 0, `pin_out[i]` = `gpio_val[i]` and `pin_oe[i]` = `gpio_oe[i]`. Pin 3 always takes `gpio_val[3]` and `gpio_oe[3]`.
- R10: Outputs are registered. A change of a static input shows at `pin_out` and `pin_oe` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | PHY link established |
| speed | input | 2 | Link speed code (00 = 10, 01 = 100, 10 = 1000, 11 = none) |
| full_duplex | input | 1 | PHY is in full duplex |
| activity | input | 1 | One-cycle strobe per transmitted or received frame |
| mode_word | input | 16 | Three 5-bit LED selection fields plus master bit 15 |
| pin_led_en | input | 3 | Per-pin LED function select for pins 0 to 2 |
| gpio_val | input | 4 | Host-written pin values |
| gpio_oe | input | 4 | Host-written output enables |
| pin_out | output | 4 | Registered pin values |
| pin_oe | output | 4 | Registered pin output enables |

## Verification
The bench goes after the speed code 2'b11, which must light no speed LED; a decoder that maps it onto 1000 would light gigabit LEDs with no valid link. It clears the master bit with non-default fields present and expects the fixed defaults; a design that ignores the master bit would follow the garbage fields. It times the activity stretch edge by edge, so an off-by-one counter shows up on the last lit cycle or the first dark one. It also holds traffic on a link-plus-activity LED, where a design without blinking would stay solid and one that blinks without activity would flicker on an idle link. Random mode words, including all-zero fields, check the field offsets, the OR of speeds and the duplex AND against a bench model.

// File: rtl/led_map_pkg.sv
package led_map_pkg;

  localparam int LED_N   = 3;
  localparam int FIELD_W = 5;
  localparam int PIN_N   = 4;
  localparam int MODE_W  = LED_N * FIELD_W + 1;
  localparam int MASTER_BIT = MODE_W - 1;

  typedef struct packed {
    logic duplex;
    logic s1000;
    logic s100;
    logic s10;
    logic act;
  } led_field_t;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_NONE = 2'b11
  } speed_code_e;

  localparam led_field_t DEF_LED0 = 5'b00001;
  localparam led_field_t DEF_LED1 = 5'b01110;
  localparam led_field_t DEF_LED2 = 5'b01111;

  function automatic led_field_t default_field(input int idx);
    case (idx)
      0:       return DEF_LED0;
      1:       return DEF_LED1;
      default: return DEF_LED2;
    endcase
  endfunction

endpackage

// File: rtl/led_activity_timer.sv
module led_activity_timer #(
  parameter int STRETCH_CYCLES = 2_500_000,
  parameter int BLINK_HALF     = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  output logic stretch_on,
  output logic blink_phase
);

  localparam int SW = ($clog2(STRETCH_CYCLES + 1) > 0) ? $clog2(STRETCH_CYCLES + 1) : 1;
  localparam int BW = ($clog2(BLINK_HALF) > 0) ? $clog2(BLINK_HALF) : 1;
  localparam logic [SW-1:0] S_LOAD = SW'(STRETCH_CYCLES);
  localparam logic [BW-1:0] B_LAST = BW'(BLINK_HALF - 1);

  logic [SW-1:0] stretch_cnt;
  logic [BW-1:0] blink_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stretch_cnt <= '0;
    end else if (activity) begin
      stretch_cnt <= S_LOAD;
    end else if (stretch_cnt != '0) begin
      stretch_cnt <= stretch_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blink_cnt   <= '0;
      blink_phase <= 1'b0;
    end else if (blink_cnt == B_LAST) begin
      blink_cnt   <= '0;
      blink_phase <= ~blink_phase;
    end else begin
      blink_cnt <= blink_cnt + 1'b1;
    end
  end

  assign stretch_on = (stretch_cnt != '0);

  // R6: a strobe always opens a stretch window on the next cycle
  p_strobe_opens_r6: assert property (@(posedge clk) disable iff (rst)
    activity |=> stretch_on);

  // R6: the window counter never exceeds its load value
  p_stretch_bound_r6: assert property (@(posedge clk) disable iff (rst)
    stretch_cnt <= S_LOAD);

  // R7: the blink phase only flips at the end of a half period
  p_blink_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (blink_cnt != B_LAST) |=> $stable(blink_phase));

endmodule

// File: rtl/led_field_eval.sv
module led_field_eval
  import led_map_pkg::*;
(
  input  led_field_t  field,
  input  logic        link_up,
  input  logic [1:0]  speed,
  input  logic        full_duplex,
  input  logic        stretch_on,
  input  logic        blink_phase,
  output logic        lit
);

  logic any_speed_sel;
  logic speed_hit;
  logic link_sel;
  logic link_ok;

  always_comb begin
    any_speed_sel = field.s10 | field.s100 | field.s1000;
    speed_hit = (field.s10   && speed == SPD_10)  ||
                (field.s100  && speed == SPD_100) ||
                (field.s1000 && speed == SPD_1000);
    link_sel = any_speed_sel | field.duplex;
    link_ok  = link_up
             && (!any_speed_sel || speed_hit)
             && (!field.duplex  || full_duplex);

    if (field == '0) begin
      lit = 1'b0;
    end else if (link_sel) begin
      lit = link_ok && !(field.act && stretch_on && blink_phase);
    end else begin
      lit = stretch_on;
    end
  end

endmodule

// File: rtl/led_pin_mapper.sv
module led_pin_mapper
  import led_map_pkg::*;
#(
  parameter int STRETCH_CYCLES = 2_500_000,
  parameter int BLINK_HALF     = 2_500_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        link_up,
  input  logic [1:0]  speed,
  input  logic        full_duplex,
  input  logic        activity,
  input  logic [15:0] mode_word,
  input  logic [2:0]  pin_led_en,
  input  logic [3:0]  gpio_val,
  input  logic [3:0]  gpio_oe,
  output logic [3:0]  pin_out,
  output logic [3:0]  pin_oe
);

  logic stretch_on;
  logic blink_phase;
  led_field_t        eff_field [LED_N];
  logic [LED_N-1:0]  led_lit;

  led_activity_timer #(
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .BLINK_HALF    (BLINK_HALF)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .activity   (activity),
    .stretch_on (stretch_on),
    .blink_phase(blink_phase)
  );

  for (genvar i = 0; i < LED_N; i++) begin : g_led
    always_comb begin
      if (mode_word[MASTER_BIT]) eff_field[i] = mode_word[i*FIELD_W +: FIELD_W];
      else                       eff_field[i] = default_field(i);
    end

    led_field_eval u_eval (
      .field      (eff_field[i]),
      .link_up    (link_up),
      .speed      (speed),
      .full_duplex(full_duplex),
      .stretch_on (stretch_on),
      .blink_phase(blink_phase),
      .lit        (led_lit[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else if (pin_led_en[i]) begin
        pin_out[i] <= led_lit[i];
        pin_oe[i]  <= 1'b1;
      end else begin
        pin_out[i] <= gpio_val[i];
        pin_oe[i]  <= gpio_oe[i];
      end
    end

    // R9: LED function always drives the pin
    p_led_drives_r9: assert property (@(posedge clk) disable iff (rst)
      pin_led_en[i] |=> pin_oe[i]);

    // R8: an empty field gives a dark LED
    p_zero_off_r8: assert property (@(posedge clk) disable iff (rst)
      (pin_led_en[i] && eff_field[i] == '0) |=> !pin_out[i]);

    // R4: no link means no light for fields without activity
    p_linkdown_r4: assert property (@(posedge clk) disable iff (rst)
      (pin_led_en[i] && !link_up && !eff_field[i].act) |=> !pin_out[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out[PIN_N-1] <= 1'b0;
      pin_oe[PIN_N-1]  <= 1'b0;
    end else begin
      pin_out[PIN_N-1] <= gpio_val[PIN_N-1];
      pin_oe[PIN_N-1]  <= gpio_oe[PIN_N-1];
    end
  end

  // R9: the last pin follows the host value and enable only
  p_gpio_only_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_out[3] == $past(gpio_val[3]) && pin_oe[3] == $past(gpio_oe[3])));

endmodule

// File: tb/led_pin_mapper_test.sv
module led_pin_mapper_test;

  localparam int STRETCH = 8;
  localparam int BHALF   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_up = 1'b0;
  logic [1:0]  speed = 2'b00;
  logic        full_duplex = 1'b0;
  logic        activity = 1'b0;
  logic [15:0] mode_word = 16'h0000;
  logic [2:0]  pin_led_en = 3'b111;
  logic [3:0]  gpio_val = 4'h0;
  logic [3:0]  gpio_oe = 4'h0;
  logic [3:0]  pin_out;
  logic [3:0]  pin_oe;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  led_pin_mapper #(.STRETCH_CYCLES(STRETCH), .BLINK_HALF(BHALF)) uut (
    .clk(clk), .rst(rst), .link_up(link_up), .speed(speed),
    .full_duplex(full_duplex), .activity(activity), .mode_word(mode_word),
    .pin_led_en(pin_led_en), .gpio_val(gpio_val), .gpio_oe(gpio_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Static LED model (no activity stretch running)
  function automatic logic exp_led(input logic [4:0] f, input logic lk,
                                   input logic [1:0] sp, input logic fd);
    logic spd_sel, hit;
    spd_sel = |f[3:1];
    hit = (f[1] && sp == 2'b00) || (f[2] && sp == 2'b01) || (f[3] && sp == 2'b10);
    if (f == 5'b0) return 1'b0;
    if (spd_sel || f[4]) return lk && (!spd_sel || hit) && (!f[4] || fd);
    return 1'b0;
  endfunction

  function automatic logic [4:0] eff(input logic [15:0] m, input int i);
    if (m[15]) return m[i*5 +: 5];
    case (i)
      0: return 5'b00001;
      1: return 5'b01110;
      default: return 5'b01111;
    endcase
  endfunction

  function automatic logic [7:0] exp_pins(input logic [15:0] m, input logic [2:0] en,
                                          input logic [3:0] gv, input logic [3:0] go,
                                          input logic lk, input logic [1:0] sp, input logic fd);
    logic [3:0] o, e;
    for (int i = 0; i < 3; i++) begin
      o[i] = en[i] ? exp_led(eff(m, i), lk, sp, fd) : gv[i];
      e[i] = en[i] ? 1'b1 : go[i];
    end
    o[3] = gv[3];
    e[3] = go[3];
    return {e, o};
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_init;
    int on_cnt;
    int off_cnt;
    logic [7:0] ep;
    seed_init = $urandom(32'h5EED_0017);

    // R1: reset state
    gpio_val = 4'hF; gpio_oe = 4'hF;
    step(3);
    check(pin_out, 4'h0, "R1 reset pin_out");
    check(pin_oe,  4'h0, "R1 reset pin_oe");
    rst = 1'b0;
    gpio_val = 4'h0; gpio_oe = 4'h0;
    step(STRETCH + 4);

    // R10 + R9: gpio pass-through, one edge latency
    pin_led_en = 3'b000; gpio_val = 4'b1010; gpio_oe = 4'b0110;
    step(1);
    check(pin_out, 4'b1010, "R10 R9 gpio out after one edge");
    check(pin_oe,  4'b0110, "R9 gpio oe");

    // R9: LED enable drives oe, pin3 remains gpio
    pin_led_en = 3'b111; gpio_oe = 4'b0000; gpio_val = 4'b1000;
    link_up = 1'b1; speed = 2'b10; full_duplex = 1'b1; mode_word = 16'h0000;
    step(1);
    check(pin_oe, 4'b0111, "R9 led oe, pin3 gpio oe");
    // R3: defaults -> LED0 activity only off, LED1 on, LED2 on
    check(pin_out, 4'b1110, "R3 defaults idle");

    // R3: master bit clear ignores fields
    mode_word = 16'h7FFF & 16'b0_00000_00000_00000;
    mode_word = 16'b0_00001_00001_11110;
    step(1);
    check(pin_out, 4'b1110, "R3 fields ignored without master bit");

    // R2: field positions: LED0=10 only, LED1=100 only, LED2=1000 only
    mode_word = {1'b1, 5'b01000, 5'b00100, 5'b00010};
    speed = 2'b01;
    step(1);
    check(pin_out, 4'b1010, "R2 LED1 at 100");
    speed = 2'b00;
    step(1);
    check(pin_out, 4'b1001, "R2 LED0 at 10");
    speed = 2'b10;
    step(1);
    check(pin_out, 4'b1100, "R2 LED2 at 1000");

    // R4: speed code 11 lights nothing; link down lights nothing
    mode_word = {1'b1, 5'b01110, 5'b01110, 5'b01110};
    speed = 2'b11;
    step(1);
    check(pin_out, 4'b1000, "R4 speed code none");
    speed = 2'b01; link_up = 1'b0;
    step(1);
    check(pin_out, 4'b1000, "R4 link down");
    link_up = 1'b1;

    // R5: duplex qualifier
    mode_word = {1'b1, 5'b10000, 5'b10100, 5'b10010};
    full_duplex = 1'b0;
    step(1);
    check(pin_out, 4'b1000, "R5 half duplex dark");
    full_duplex = 1'b1;
    step(1);
    check(pin_out, 4'b1110, "R5 full duplex, 100 speed");

    // R8: zero fields
    mode_word = {1'b1, 5'b00000, 5'b00000, 5'b00000};
    step(1);
    check(pin_out, 4'b1000, "R8 zero fields dark");

    // R6: activity-only stretch timing on LED0
    mode_word = {1'b1, 5'b00000, 5'b00000, 5'b00001};
    step(1);
    check(pin_out, 4'b1000, "R6 idle before strobe");
    activity = 1'b1;
    step(1);
    activity = 1'b0;
    step(1);
    check(pin_out, 4'b1001, "R6 lit after strobe");
    step(STRETCH - 1);
    check(pin_out, 4'b1001, "R6 lit on last stretch cycle");
    step(1);
    check(pin_out, 4'b1000, "R6 dark after stretch");

    // R7: link + activity on LED2: solid idle, blinks under traffic
    mode_word = {1'b1, 5'b01111, 5'b00000, 5'b00000};
    step(STRETCH + 2);
    on_cnt = 0; off_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (pin_out[2]) on_cnt++; else off_cnt++;
    end
    check({3'b0, off_cnt == 0}, 4'b0001, "R7 solid while idle");
    on_cnt = 0; off_cnt = 0;
    activity = 1'b1;
    for (int k = 0; k < 24; k++) begin
      step(1);
      if (pin_out[2]) on_cnt++; else off_cnt++;
    end
    activity = 1'b0;
    check({2'b0, on_cnt > 0, off_cnt > 0}, 4'b0011, "R7 blinks under traffic");
    step(STRETCH + 2 * BHALF + 2);
    check(pin_out & 4'b0100, 4'b0100, "R7 solid again after traffic");

    // Random static patterns (no activity)
    for (int n = 0; n < 200; n++) begin
      mode_word   = 16'($urandom);
      pin_led_en  = 3'($urandom);
      gpio_val    = 4'($urandom);
      gpio_oe     = 4'($urandom);
      link_up     = 1'($urandom);
      speed       = 2'($urandom);
      full_duplex = 1'($urandom);
      if (n % 5 == 0) mode_word[4:0] = 5'b0;
      step(1);
      ep = exp_pins(mode_word, pin_led_en, gpio_val, gpio_oe, link_up, speed, full_duplex);
      check(pin_out, ep[3:0], "R2 R4 R5 R8 R9 random pin_out");
      check(pin_oe,  ep[7:4], "R9 random pin_oe");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule